// File: doc/BRIEF.md
# Interrupt Controller Status-Read and Poll Unit

This unit implements the status-read and poll side of an eight-level interrupt controller. It sits behind a small CPU register bus with two ports. The command port (address 0) accepts operation control words and returns status on reads. The data port (address 1) holds the interrupt mask. Request inputs are latched into a request register. Service state lives in an in-service register that this unit sets on poll acknowledges and that an init pulse clears.

Software picks which status register the command port returns, and that choice stays in place until software changes it. Software can also arm a one-shot poll. The command-port read that follows it becomes an acknowledge. That read returns an encoded byte naming the winning level, moves the winner from pending to in-service, and disarms the poll. A special mask mode changes the priority rule: in-service levels that are masked stop blocking lower-priority requests. A service routine can use this to open the way for other channels while it runs.

Top module: `pic_status_poll`

## Requirements
- R1: After reset or an `init` pulse, the command port reads the request register, poll is disarmed, special mask mode is off, and the in-service and mask registers are zero. `init` leaves the request register unchanged.
- R2: A command-port write is taken as a control word only when bits 4:3 equal 01. Any other value in bits 4:3 changes neither the read selection, nor poll, nor special mask mode.
- R3: In a control word with bit 1 set, bit 0 chooses the status source: 0 selects the request register and 1 selects the in-service register. When bit 1 is clear, the selection is kept and bit 0 has no effect.
- R4: The selected status register can be read any number of times without a new control word.
- R5: A control word with bit 2 set arms poll. The next command-port read returns bit 7 = 1 and the winning level in bits 2:0. If no request can win, that read returns 0x00.
- R6: Poll disarms after exactly one command-port read, whether or not a request won. Data-port reads do not disarm it.
- R7: A poll read that finds a winner sets that level's in-service bit and clears its request bit.
- R8: Priority is fixed, with level 0 highest. Masked requests never win. With special mask mode off, a request wins only if its level is numerically lower than every in-service level.
- R9: Bit 6 of a control word sets or clears special mask mode only when bit 5 of the same word is 1. With the mode on, in-service levels whose mask bit is set no longer block lower-priority requests.
- R10: A data-port write loads the mask register, and a data-port read returns it.
- R11: Read data is registered. It changes on the clock edge that samples the read strobe and holds while no read is issued.
- R12: A request input that is high on a clock edge sets its request bit. The bit stays set after the input falls, until a poll acknowledges that level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Initialization pulse |
| addr | input | 1 | Port select: 0 command, 1 data (mask) |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| irq_in | input | NUM_IRQ | Request inputs, active high |
| rdata | output | 8 | Registered read data |

## Verification
The bench targets several corner cases, each tied to a specific fault:
- A control word with bit 1 clear but bit 0 set must keep the current selection. A design that decodes bit 0 alone would switch status sources behind software's back.
- A poll read with nothing eligible must still disarm poll. A design that disarms only on a hit would turn the following status read into a spurious acknowledge.
- A masked in-service level above a pending request must block that request while special mask mode is off and stop blocking it once the mode is on. A design that ignores the mode, or applies the mode bit without its enable bit, returns the wrong level.
- Writes with other values in bits 4:3 and data-port reads between an arm and its read must leave poll untouched.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned DATA_W = 8;
  localparam logic [1:0] CW3_TAG = 2'b01;

  typedef enum logic {
    SEL_REQ = 1'b0,
    SEL_SVC = 1'b1
  } rd_sel_e;

  // control word bit positions (decoded by software-visible behaviour)
  localparam int unsigned B_SELSRC  = 0;
  localparam int unsigned B_SELEN   = 1;
  localparam int unsigned B_POLL    = 2;
  localparam int unsigned B_SMM_EN  = 5;
  localparam int unsigned B_SMM_VAL = 6;
endpackage

// File: rtl/pic_cw3_ctrl.sv
module pic_cw3_ctrl
  import pic_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       init,
  input  logic       cmd_wr,
  input  logic       cmd_rd,
  input  logic [6:0] cw,
  output rd_sel_e    sel_q,
  output logic       poll_q,
  output logic       smm_q
);
  logic is_cw3;
  assign is_cw3 = cmd_wr && (cw[4:3] == CW3_TAG);

  always_ff @(posedge clk) begin
    if (rst || init) begin
      sel_q  <= SEL_REQ;
      poll_q <= 1'b0;
      smm_q  <= 1'b0;
    end else begin
      if (cmd_rd && poll_q) poll_q <= 1'b0;
      if (is_cw3) begin
        if (cw[B_SELEN])  sel_q  <= rd_sel_e'(cw[B_SELSRC]);
        if (cw[B_POLL])   poll_q <= 1'b1;
        if (cw[B_SMM_EN]) smm_q  <= cw[B_SMM_VAL];
      end
    end
  end

  // R6: one read consumes the poll
  assert_poll_oneshot_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_rd && poll_q && !cmd_wr && !init) |=> !poll_q);
  // R3: selection sticky unless enable bit written
  assert_sel_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (!init && !(cmd_wr && cw[4:3] == CW3_TAG && cw[B_SELEN])) |=> $stable(sel_q));
  // R9: mode bit needs its enable
  assert_smm_needs_en_R9: assert property (@(posedge clk) disable iff (rst)
    (!init && !(cmd_wr && cw[4:3] == CW3_TAG && cw[B_SMM_EN])) |=> $stable(smm_q));
  // R2: foreign command words do not arm poll
  assert_foreign_word_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cw[4:3] != CW3_TAG && !cmd_rd && !init) |=> $stable(poll_q));
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
  parameter int unsigned NUM_IRQ = 8,
  localparam int unsigned LVL_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irr,
  input  logic [NUM_IRQ-1:0] isr,
  input  logic [NUM_IRQ-1:0] imr,
  input  logic               smm,
  output logic               win_valid,
  output logic [LVL_W-1:0]   win_lvl,
  output logic [NUM_IRQ-1:0] win_oh
);
  logic [NUM_IRQ-1:0] cand, block, blk_chain, elig, seen, le_mask;

  assign cand  = irr & ~imr;
  assign block = smm ? (isr & ~imr) : isr;

  assign blk_chain[0] = block[0];
  assign seen[0]      = elig[0];
  assign win_oh[0]    = elig[0];
  assign elig         = cand & ~blk_chain;

  for (genvar g = 1; g < NUM_IRQ; g++) begin : g_chain
    assign blk_chain[g] = blk_chain[g-1] | block[g];
    assign seen[g]      = seen[g-1] | elig[g];
    assign win_oh[g]    = elig[g] & ~seen[g-1];
  end

  assign win_valid = seen[NUM_IRQ-1];

  always_comb begin
    win_lvl = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (win_oh[i]) win_lvl = LVL_W'(i);
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_le
    assign le_mask[g] = (win_lvl >= LVL_W'(g));
  end

  // R8: a masked request never wins
  assert_masked_never_wins_R8: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (imr[win_lvl] == 1'b0 && irr[win_lvl] == 1'b1));
  // R8: strict mode, no in-service level at or above winner's priority
  assert_strict_block_R8: assert property (@(posedge clk) disable iff (rst)
    (win_valid && !smm) |-> ((isr & le_mask) == '0));
  // R9: special mode, only unmasked service levels block
  assert_smm_block_R9: assert property (@(posedge clk) disable iff (rst)
    (win_valid && smm) |-> ((isr & ~imr & le_mask) == '0));
endmodule

// File: rtl/pic_status_regs.sv
module pic_status_regs #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               init,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               mask_wr,
  input  logic [NUM_IRQ-1:0] mask_wdata,
  input  logic               ack,
  input  logic [NUM_IRQ-1:0] ack_oh,
  output logic [NUM_IRQ-1:0] irr_q,
  output logic [NUM_IRQ-1:0] isr_q,
  output logic [NUM_IRQ-1:0] imr_q
);
  logic [NUM_IRQ-1:0] take;
  assign take = ack ? ack_oh : '0;

  always_ff @(posedge clk) begin
    if (rst) irr_q <= '0;
    else     irr_q <= (irr_q | irq_in) & ~take;
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      isr_q <= '0;
      imr_q <= '0;
    end else begin
      isr_q <= isr_q | take;
      if (mask_wr) imr_q <= mask_wdata;
    end
  end

  // R7: acknowledged level enters service
  assert_ack_sets_isr_R7: assert property (@(posedge clk) disable iff (rst)
    (ack && !init) |=> ((isr_q & $past(ack_oh)) == $past(ack_oh)));
  // R1: init clears service and mask state
  assert_init_clears_R1: assert property (@(posedge clk) disable iff (rst)
    init |=> (isr_q == '0 && imr_q == '0));
  // R12: a high input is captured unless acknowledged in that cycle
  assert_irq_latched_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(irq_in & ~take) & ~irr_q) == '0));
endmodule

// File: rtl/pic_status_poll.sv
module pic_status_poll
  import pic_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  localparam int unsigned LVL_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               init,
  input  logic               addr,
  input  logic               wr,
  input  logic               rd,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic [DATA_W-1:0]  rdata
);
  logic               cmd_wr, cmd_rd, mask_wr, ack;
  rd_sel_e            sel_q;
  logic               poll_q, smm_q, win_valid;
  logic [LVL_W-1:0]   win_lvl;
  logic [NUM_IRQ-1:0] win_oh, irr_q, isr_q, imr_q;
  logic [DATA_W-1:0]  poll_byte, stat_byte, rdata_d;

  assign cmd_wr  = wr && !addr;
  assign cmd_rd  = rd && !addr;
  assign mask_wr = wr && addr;
  assign ack     = cmd_rd && poll_q && win_valid;

  pic_cw3_ctrl u_ctrl (
    .clk(clk), .rst(rst), .init(init), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
    .cw(wdata[6:0]), .sel_q(sel_q), .poll_q(poll_q), .smm_q(smm_q)
  );

  pic_prio_resolve #(.NUM_IRQ(NUM_IRQ)) u_prio (
    .clk(clk), .rst(rst), .irr(irr_q), .isr(isr_q), .imr(imr_q), .smm(smm_q),
    .win_valid(win_valid), .win_lvl(win_lvl), .win_oh(win_oh)
  );

  pic_status_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk(clk), .rst(rst), .init(init), .irq_in(irq_in),
    .mask_wr(mask_wr), .mask_wdata(wdata[NUM_IRQ-1:0]),
    .ack(ack), .ack_oh(win_oh),
    .irr_q(irr_q), .isr_q(isr_q), .imr_q(imr_q)
  );

  assign poll_byte = win_valid ? {1'b1, {(DATA_W-1-LVL_W){1'b0}}, win_lvl} : '0;
  assign stat_byte = (sel_q == SEL_SVC) ? DATA_W'(isr_q) : DATA_W'(irr_q);

  always_comb begin
    if (addr)        rdata_d = DATA_W'(imr_q);
    else if (poll_q) rdata_d = poll_byte;
    else             rdata_d = stat_byte;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rdata_d;
  end

  // R11: output holds without a read
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
  // R5: poll response leaves unused bits zero
  assert_poll_format_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_rd && poll_q) |=> (rdata[DATA_W-2:LVL_W] == '0));
  // R10: data-port read returns the mask
  assert_mask_read_R10: assert property (@(posedge clk) disable iff (rst)
    (rd && addr && !init && !wr) |=> (rdata == DATA_W'($past(imr_q))));
endmodule

// File: tb/pic_status_poll_tb_top.sv
module pic_status_poll_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0, rst = 1'b1, init = 1'b0, addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [N-1:0] irq_in = '0;
  logic [7:0] rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [N-1:0] m_irr, m_isr, m_imr;
  bit m_sel, m_poll, m_smm;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_status_poll #(.NUM_IRQ(N)) dut_i (
    .clk(clk), .rst(rst), .init(init), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .irq_in(irq_in), .rdata(rdata)
  );

  function automatic logic [7:0] model_poll(output int lvl);
    logic [N-1:0] blk;
    blk = m_smm ? (m_isr & ~m_imr) : m_isr;
    lvl = -1;
    for (int i = 0; i < N; i++) begin
      if (blk[i]) break;
      if (m_irr[i] && !m_imr[i]) begin lvl = i; break; end
    end
    return (lvl < 0) ? 8'h00 : (8'h80 | 8'(lvl));
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic model_init();
    m_isr = '0; m_imr = '0; m_sel = 0; m_poll = 0; m_smm = 0;
  endtask

  task automatic do_write(input bit a, input logic [7:0] d);
    @(negedge clk); addr = a; wr = 1; wdata = d;
    @(negedge clk); wr = 0;
    if (a) m_imr = d;
    else if (d[4:3] == 2'b01) begin
      if (d[1]) m_sel = d[0];
      if (d[2]) m_poll = 1;
      if (d[5]) m_smm = d[6];
    end
  endtask

  task automatic do_read(input bit a, input string tag);
    logic [7:0] exp;
    int lvl;
    if (a) exp = m_imr;
    else if (m_poll) begin
      exp = model_poll(lvl);
      if (lvl >= 0) begin m_isr[lvl] = 1; m_irr[lvl] = 0; end
      m_poll = 0;
    end else exp = m_sel ? m_isr : m_irr;
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0;
    check(rdata, exp, tag);
  endtask

  task automatic pulse_irq(input logic [N-1:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk); irq_in = '0;
    m_irr = m_irr | v;
  endtask

  task automatic pulse_init();
    @(negedge clk); init = 1;
    @(negedge clk); init = 0;
    model_init();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] hold;
    void'($urandom(32'd4711));
    m_irr = '0; model_init();
    repeat (3) @(negedge clk);
    rst = 0;
    check(rdata, 8'h00, "R1 reset rdata");
    do_read(0, "R1 default IRR");
    do_read(1, "R1 mask zero");
    pulse_irq(8'hA0);
    do_read(0, "R12 latched requests");
    do_read(0, "R4 repeat read");
    do_write(0, 8'h0B);
    do_read(0, "R3 select ISR");
    do_write(0, 8'h09);
    do_read(0, "R3 bit0 ignored without bit1");
    do_write(0, 8'h0C);
    do_read(0, "R5 poll hit level 5");
    do_read(0, "R6 R7 poll consumed, ISR set");
    do_write(0, 8'h0A);
    do_read(0, "R7 IRR bit cleared");
    do_write(0, 8'h0C);
    do_read(0, "R8 blocked by in-service level");
    do_read(0, "R6 disarmed after empty poll");
    do_write(1, 8'h20);
    do_read(1, "R10 mask readback");
    do_write(0, 8'h68);
    do_write(0, 8'h0C);
    do_read(1, "R6 data read keeps poll");
    do_read(0, "R9 masked service level unblocks");
    pulse_init();
    do_read(0, "R1 init selects IRR");
    do_read(1, "R1 init clears mask");
    do_write(1, 8'h01);
    pulse_irq(8'h41);
    do_write(0, 8'h0C);
    do_read(0, "R8 masked request skipped");
    pulse_irq(8'h80);
    do_write(1, 8'h41);
    do_write(0, 8'h0C);
    do_read(0, "R8 strict mode blocks");
    do_write(0, 8'h48);
    do_write(0, 8'h0C);
    do_read(0, "R9 mode bit without enable");
    do_write(0, 8'h68);
    do_write(0, 8'h1E);
    do_read(0, "R2 foreign word no poll");
    do_write(0, 8'h0C);
    do_read(0, "R9 special mode grants level 7");
    hold = rdata;
    repeat (4) @(negedge clk);
    check(rdata, hold, "R11 hold without read");

    for (int k = 0; k < 1500; k++) begin
      int op = $urandom_range(0, 99);
      logic [7:0] d = 8'($urandom);
      if (op < 25) begin
        if ($urandom_range(0, 3) != 0) d[4:3] = 2'b01;
        do_write(0, d);
      end else if (op < 33) do_write(1, d);
      else if (op < 60) do_read(0, "R5 R3 random cmd read");
      else if (op < 68) do_read(1, "R10 random mask read");
      else if (op < 95) pulse_irq(N'($urandom));
      else pulse_init();
    end
    finish_run();
  end
endmodule